// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer with R1 Decode

The engine sends one SD-card command over a byte-wide SPI link and collects the answer. A separate byte shifter, outside this block, moves the bytes. When `start` is pulsed in the idle state, the engine captures the command index, the 32-bit argument, the response-type flags and the block geometry. It then requests byte transfers one at a time: a 0xFF spacer, the six-byte command frame ending in its CRC7, one discarded byte, and a bounded hunt for the R1 byte.

A valid R1 is decoded for errors in a fixed priority. If R1 is clean, the engine can poll for the end of card busy and can read a trailing one-byte or four-byte response. It finishes with a one-cycle `done` pulse that carries an error code and the response word. On success, `pos_clr` is raised with `done` to tell the data path to restart its transfer position, and the block size and block count are latched for the data phase.

States: IDLE waits for `start` and goes to SPACER. SPACER goes to FRAME after one byte. FRAME goes to SKIP after six bytes. SKIP goes to HUNT after one byte. HUNT goes to FINISH on an R1 error or a hunt timeout. On a clean R1, HUNT goes to BUSY if the busy flag is set, otherwise to TRAIL if a trailing response is requested, otherwise to FINISH. BUSY goes to TRAIL or FINISH once busy ends, and to FINISH on a busy timeout. TRAIL goes to FINISH after its last byte. FINISH returns to IDLE after one cycle.

Top module: `sdspi_cmd_engine`

## Requirements
- R1: The first byte requested after `start` is 0xFF. `xfer_req` stays low while the engine is idle.
- R2: Frame bytes 0 to 4 are 0x40 OR the 6-bit index, followed by the argument with its most significant byte first.
- R3: Frame byte 5 is {crc7, 1}. The CRC7 uses polynomial x^7+x^3+1 with initial value 0 and is computed over frame bytes 0 to 4, MSB first.
- R4: The byte that follows the frame is discarded whatever its value. The first of up to HUNT_TRIES further bytes with bit 7 = 0 is taken as R1, and R1 is placed in `resp[7:0]` with zeros above it.
- R5: If no byte with bit 7 = 0 arrives within HUNT_TRIES reads, `err_code` = 1 (response timeout), after exactly 8 + HUNT_TRIES transfers.
- R6: R1 is decoded in priority order. Bit 3 gives code 2 (response CRC). Otherwise bit 2 gives code 3 (illegal command). Otherwise any of bits 1, 4, 5 or 6 gives code 4 (generic). Bit 0 (idle) alone gives code 0. After any R1 error, no further byte is transferred.
- R7: With `rsp_busy` set and a clean R1, the engine reads bytes until one equals 0xFF. If BUSY_LIMIT reads all differ from 0xFF, `err_code` = 5 (busy timeout).
- R8: With `rsp_word` set, four trailing bytes are read and packed most significant first into `resp`. With only `rsp_byte` set, one byte is read into `resp[7:0]` and the upper bits are zero. `rsp_word` takes precedence when both flags are set.
- R9: On success, `pos_clr` pulses together with `done`, and `blk_size_o` and `blk_count_o` take the values captured at `start` from the next cycle on. On any error they keep their previous values.
- R10: `done` is a one-cycle pulse. Every byte sent outside the frame is 0xFF, and the total transfer count matches the path taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a command; acted on only in IDLE |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_busy | input | 1 | Response includes busy signalling |
| rsp_byte | input | 1 | One trailing response byte follows R1 |
| rsp_word | input | 1 | Four trailing response bytes follow R1 |
| blk_size | input | BLK_W | Block size for the following data phase |
| blk_count | input | BLK_W | Block count for the following data phase |
| xfer_req | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | One-cycle pulse: transfer finished, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received |
| done | output | 1 | Command finished (one cycle) |
| err_code | output | 3 | 0 ok, 1 response timeout, 2 response CRC, 3 illegal command, 4 generic, 5 busy timeout |
| resp | output | 32 | R1 or trailing response |
| blk_size_o | output | BLK_W | Latched block size |
| blk_count_o | output | BLK_W | Latched block count |
| pos_clr | output | 1 | Restart transfer position (success only) |

## Verification
The bench builds the engine with BUSY_LIMIT = 6 and the default HUNT_TRIES = 7. With these values, the busy-timeout boundary and every possible R1 arrival slot, including the slot past the window, take only a few transfers each.

That short run lets the bench sweep all 64 command indices through the frame and CRC check, and all 128 R1 values with bit 7 clear through the priority decoder. It also covers every busy length from zero to the limit, and every combination of the trailing-response flags.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
    typedef enum logic [2:0] {
        SE_NONE     = 3'd0,
        SE_RSP_TMO  = 3'd1,
        SE_RSP_CRC  = 3'd2,
        SE_ILLEGAL  = 3'd3,
        SE_GENERIC  = 3'd4,
        SE_BUSY_TMO = 3'd5
    } sd_err_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPACER,
        ST_FRAME,
        ST_SKIP,
        ST_HUNT,
        ST_BUSY,
        ST_TRAIL,
        ST_FINISH
    } eng_state_e;

    localparam logic [7:0] FILL_BYTE  = 8'hFF;
    localparam logic [7:0] CMD_PREFIX = 8'h40;
    localparam int         FRAME_LEN  = 6;
    localparam int         HEAD_LEN   = FRAME_LEN - 1;
endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7 #(
    parameter int NBITS = 40
) (
    input  logic [NBITS-1:0] msg,
    output logic [6:0]       crc
);
    always_comb begin
        logic [6:0] acc;
        logic       fb;
        acc = '0;
        for (int i = NBITS - 1; i >= 0; i--) begin
            fb  = msg[i] ^ acc[6];
            acc = {acc[5:0], 1'b0};
            if (fb) begin
                acc = acc ^ 7'h09;
            end
        end
        crc = acc;
    end
endmodule

// File: rtl/sdspi_frame.sv
module sdspi_frame
    import sdspi_pkg::*;
(
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic [2:0]  sel,
    output logic [7:0]  tx_byte
);
    localparam int HEAD_BITS = HEAD_LEN * 8;

    logic [HEAD_BITS-1:0] head;
    logic [6:0]           crc;
    logic [7:0]           bytes [FRAME_LEN];

    assign head = {CMD_PREFIX | {2'b00, idx}, arg};

    sdspi_crc7 #(.NBITS(HEAD_BITS)) u_crc (
        .msg (head),
        .crc (crc)
    );

    for (genvar g = 0; g < HEAD_LEN; g++) begin : g_head
        assign bytes[g] = head[HEAD_BITS - 1 - 8*g -: 8];
    end
    assign bytes[HEAD_LEN] = {crc, 1'b1};

    always_comb begin
        if (int'(sel) < FRAME_LEN) begin
            tx_byte = bytes[sel];
        end else begin
            tx_byte = FILL_BYTE;
        end
    end
endmodule

// File: rtl/sdspi_r1_dec.sv
module sdspi_r1_dec
    import sdspi_pkg::*;
(
    input  logic [7:0] r1,
    output sd_err_e    code
);
    localparam int BIT_IDLE    = 0;
    localparam int BIT_ILLEGAL = 2;
    localparam int BIT_CRC     = 3;

    logic [7:0] other_mask;
    assign other_mask = 8'h7F & ~(8'(1) << BIT_IDLE);

    always_comb begin
        if (r1[BIT_CRC]) begin
            code = SE_RSP_CRC;
        end else if (r1[BIT_ILLEGAL]) begin
            code = SE_ILLEGAL;
        end else if ((r1 & other_mask) != 8'h00) begin
            code = SE_GENERIC;
        end else begin
            code = SE_NONE;
        end
    end
endmodule

// File: rtl/sdspi_cmd_engine.sv
module sdspi_cmd_engine
    import sdspi_pkg::*;
#(
    parameter int HUNT_TRIES = 7,
    parameter int BUSY_LIMIT = 1024,
    parameter int BLK_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       cmd_idx,
    input  logic [31:0]      cmd_arg,
    input  logic             rsp_busy,
    input  logic             rsp_byte,
    input  logic             rsp_word,
    input  logic [BLK_W-1:0] blk_size,
    input  logic [BLK_W-1:0] blk_count,
    output logic             xfer_req,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_ack,
    input  logic [7:0]       xfer_rx,
    output logic             done,
    output logic [2:0]       err_code,
    output logic [31:0]      resp,
    output logic [BLK_W-1:0] blk_size_o,
    output logic [BLK_W-1:0] blk_count_o,
    output logic             pos_clr
);
    localparam int CNT_MAX = (BUSY_LIMIT > HUNT_TRIES) ? BUSY_LIMIT : HUNT_TRIES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HUNT_LAST  = CNT_W'(HUNT_TRIES - 1);
    localparam logic [CNT_W-1:0] BUSY_LAST  = CNT_W'(BUSY_LIMIT - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

    eng_state_e       state, state_n;
    logic [CNT_W-1:0] cnt;
    logic [5:0]       idx_q;
    logic [31:0]      arg_q;
    logic             busy_q;
    logic [2:0]       trail_n;
    logic [31:0]      resp_q;
    sd_err_e          err_q;
    sd_err_e          r1_code;
    logic [BLK_W-1:0] bs_stage, bc_stage, bs_q, bc_q;
    logic [7:0]       frame_byte;
    logic             r1_seen;
    logic             busy_end;
    eng_state_e       after_r1, after_busy;

    sdspi_frame u_frame (
        .idx     (idx_q),
        .arg     (arg_q),
        .sel     (cnt[2:0]),
        .tx_byte (frame_byte)
    );

    sdspi_r1_dec u_r1 (
        .r1   (xfer_rx),
        .code (r1_code)
    );

    assign r1_seen    = ~xfer_rx[7];
    assign busy_end   = (xfer_rx == FILL_BYTE);
    assign after_busy = (trail_n != 3'd0) ? ST_TRAIL : ST_FINISH;
    assign after_r1   = busy_q ? ST_BUSY : after_busy;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_SPACER;
            ST_SPACER: if (xfer_ack) state_n = ST_FRAME;
            ST_FRAME:  if (xfer_ack && cnt == FRAME_LAST) state_n = ST_SKIP;
            ST_SKIP:   if (xfer_ack) state_n = ST_HUNT;
            ST_HUNT: begin
                if (xfer_ack) begin
                    if (r1_seen) begin
                        state_n = (r1_code != SE_NONE) ? ST_FINISH : after_r1;
                    end else if (cnt == HUNT_LAST) begin
                        state_n = ST_FINISH;
                    end
                end
            end
            ST_BUSY: begin
                if (xfer_ack) begin
                    if (busy_end) begin
                        state_n = after_busy;
                    end else if (cnt == BUSY_LAST) begin
                        state_n = ST_FINISH;
                    end
                end
            end
            ST_TRAIL:  if (xfer_ack && cnt == CNT_W'(trail_n - 3'd1)) state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            idx_q    <= '0;
            arg_q    <= '0;
            busy_q   <= 1'b0;
            trail_n  <= '0;
            resp_q   <= '0;
            err_q    <= SE_NONE;
            bs_stage <= '0;
            bc_stage <= '0;
            bs_q     <= '0;
            bc_q     <= '0;
        end else begin
            if (state_n != state) begin
                cnt <= '0;
            end else if (xfer_ack && xfer_req) begin
                cnt <= cnt + 1'b1;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        idx_q    <= cmd_idx;
                        arg_q    <= cmd_arg;
                        busy_q   <= rsp_busy;
                        trail_n  <= rsp_word ? 3'd4 : (rsp_byte ? 3'd1 : 3'd0);
                        bs_stage <= blk_size;
                        bc_stage <= blk_count;
                        err_q    <= SE_NONE;
                    end
                end
                ST_HUNT: begin
                    if (xfer_ack) begin
                        if (r1_seen) begin
                            resp_q <= {24'h0, xfer_rx};
                            err_q  <= r1_code;
                        end else if (cnt == HUNT_LAST) begin
                            err_q <= SE_RSP_TMO;
                        end
                    end
                end
                ST_BUSY: begin
                    if (xfer_ack && !busy_end && cnt == BUSY_LAST) begin
                        err_q <= SE_BUSY_TMO;
                    end
                end
                ST_TRAIL: begin
                    if (xfer_ack) begin
                        resp_q <= (cnt == '0) ? {24'h0, xfer_rx} : {resp_q[23:0], xfer_rx};
                    end
                end
                ST_FINISH: begin
                    if (err_q == SE_NONE) begin
                        bs_q <= bs_stage;
                        bc_q <= bc_stage;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        xfer_req = 1'b0;
        xfer_tx  = FILL_BYTE;
        done     = 1'b0;
        pos_clr  = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FRAME: begin
                xfer_req = 1'b1;
                xfer_tx  = frame_byte;
            end
            ST_SPACER, ST_SKIP, ST_HUNT, ST_BUSY, ST_TRAIL: xfer_req = 1'b1;
            ST_FINISH: begin
                done    = 1'b1;
                pos_clr = (err_q == SE_NONE);
            end
            default: ;
        endcase
    end

    assign err_code    = err_q;
    assign resp        = resp_q;
    assign blk_size_o  = bs_q;
    assign blk_count_o = bc_q;
endmodule

// File: rtl/sdspi_cmd_chk.sv
module sdspi_cmd_chk #(
    parameter int HUNT_TRIES = 7,
    parameter int BUSY_LIMIT = 1024,
    parameter int BLK_W      = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             xfer_req,
    input logic             xfer_ack,
    input logic [7:0]       xfer_tx,
    input logic             done,
    input logic [2:0]       err_code,
    input logic             pos_clr,
    input logic [BLK_W-1:0] blk_size_o,
    input logic [BLK_W-1:0] blk_count_o
);
    logic [31:0] acks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks <= '0;
        end else if (start && !xfer_req && !done) begin
            acks <= '0;
        end else if (xfer_req && xfer_ack) begin
            acks <= acks + 32'd1;
        end
    end

    p_spacer_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_req) |-> xfer_tx == 8'hFF);

    p_hunt_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 3'd1) |-> acks == 32'(8 + HUNT_TRIES));

    p_busy_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == 3'd5) |-> acks >= 32'(BUSY_LIMIT + 9));

    p_clr_on_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pos_clr |-> (done && err_code == 3'd0));

    p_blk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pos_clr |=> ($stable(blk_size_o) && $stable(blk_count_o)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_req_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !xfer_req);
endmodule

bind sdspi_cmd_engine sdspi_cmd_chk #(
    .HUNT_TRIES (HUNT_TRIES),
    .BUSY_LIMIT (BUSY_LIMIT),
    .BLK_W      (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .xfer_req    (xfer_req),
    .xfer_ack    (xfer_ack),
    .xfer_tx     (xfer_tx),
    .done        (done),
    .err_code    (err_code),
    .pos_clr     (pos_clr),
    .blk_size_o  (blk_size_o),
    .blk_count_o (blk_count_o)
);

// File: tb/tb_sdspi_cmd_engine.sv
module tb_sdspi_cmd_engine;
    localparam int HT = 7;
    localparam int BL = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        rsp_busy = 1'b0, rsp_byte = 1'b0, rsp_word = 1'b0;
    logic [15:0] blk_size = '0, blk_count = '0;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'hFF;
    logic        done;
    logic [2:0]  err_code;
    logic [31:0] resp;
    logic [15:0] blk_size_o, blk_count_o;
    logic        pos_clr;

    always #5 clk = ~clk;

    sdspi_cmd_engine #(.HUNT_TRIES(HT), .BUSY_LIMIT(BL), .BLK_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .rsp_busy(rsp_busy), .rsp_byte(rsp_byte), .rsp_word(rsp_word),
        .blk_size(blk_size), .blk_count(blk_count),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
        .done(done), .err_code(err_code), .resp(resp),
        .blk_size_o(blk_size_o), .blk_count_o(blk_count_o), .pos_clr(pos_clr)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] script [64];
    logic [7:0] txlog  [64];
    int k = 0;
    logic [15:0] exp_bs = '0, exp_bc = '0;

    // card model: answers each request with the next scripted byte
    always @(negedge clk) begin
        if (xfer_ack) begin
            xfer_ack = 1'b0;
            k = k + 1;
        end else if (xfer_req && k < 64) begin
            txlog[k] = xfer_tx;
            xfer_rx  = script[k];
            xfer_ack = 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_byte(input logic [7:0] b [5]);
        logic [7:0] c;
        c = 8'h00;
        for (int i = 0; i < 5; i++) begin
            c = c ^ b[i];
            for (int j = 0; j < 8; j++) begin
                c = c[7] ? ((c << 1) ^ 8'h12) : (c << 1);
            end
        end
        return c | 8'h01;
    endfunction

    function automatic logic [2:0] r1_expect(input logic [7:0] r);
        if (r[3]) return 3'd2;
        if (r[2]) return 3'd3;
        if ((r & 8'h72) != 0) return 3'd4;
        return 3'd0;
    endfunction

    // hunt_d: slot of R1 among the hunt reads (HT = never arrives)
    task automatic run(input logic [5:0] idx, input logic [31:0] arg, input bit bsy,
                       input bit r8, input bit r32, input int hunt_d, input logic [7:0] r1,
                       input int busy_len, input logic [31:0] trail,
                       input logic [15:0] bs, input logic [15:0] bc, input string tag);
        int pos;
        int n;
        logic [2:0]  e_err;
        logic [31:0] e_resp;
        logic [7:0]  hb [5];
        logic [7:0]  fr [6];
        bit got_done;
        bit got_clr;
        for (int i = 0; i < 64; i++) script[i] = 8'hFF;
        script[7] = 8'h05;
        n = r32 ? 4 : (r8 ? 1 : 0);
        e_resp = {24'h0, r1};
        if (hunt_d >= HT) begin
            e_err = 3'd1;
            pos = 8 + HT;
        end else begin
            script[8 + hunt_d] = r1;
            pos = 8 + hunt_d + 1;
            e_err = r1_expect(r1);
            if (e_err == 0 && bsy) begin
                for (int j = 0; j < busy_len && j < BL; j++) script[pos + j] = 8'h00;
                if (busy_len >= BL) begin
                    e_err = 3'd5;
                    pos = pos + BL;
                end else begin
                    pos = pos + busy_len + 1;
                end
            end
            if (e_err == 0 && n > 0) begin
                for (int j = 0; j < n; j++) script[pos + j] = trail[8*(n-1-j) +: 8];
                pos = pos + n;
                e_resp = (n == 4) ? trail : {24'h0, trail[7:0]};
            end
        end
        hb[0] = 8'h40 | {2'b00, idx};
        hb[1] = arg[31:24]; hb[2] = arg[23:16]; hb[3] = arg[15:8]; hb[4] = arg[7:0];
        for (int i = 0; i < 5; i++) fr[i] = hb[i];
        fr[5] = crc_byte(hb);

        @(negedge clk);
        k = 0;
        cmd_idx = idx; cmd_arg = arg; rsp_busy = bsy; rsp_byte = r8; rsp_word = r32;
        blk_size = bs; blk_count = bc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 1'b0;
        for (int c = 0; c < 200 && !got_done; c++) begin
            @(negedge clk); #1;
            if (done) got_done = 1'b1;
        end
        chk(got_done, {"R10 done seen ", tag}, 32'(got_done), 32'd1);
        got_clr = pos_clr;
        chk(err_code == e_err, {"R5/R6/R7 error code ", tag}, 32'(err_code), 32'(e_err));
        if (e_err != 3'd1)
            chk(resp == e_resp, {"R4/R8 response ", tag}, resp, e_resp);
        chk(k == pos, {"R10 transfer count ", tag}, 32'(k), 32'(pos));
        chk(txlog[0] == 8'hFF, {"R1 spacer ", tag}, 32'(txlog[0]), 32'hFF);
        for (int i = 0; i < 5; i++)
            chk(txlog[1 + i] == fr[i], {"R2 frame byte ", tag}, 32'(txlog[1 + i]), 32'(fr[i]));
        chk(txlog[6] == fr[5], {"R3 crc byte ", tag}, 32'(txlog[6]), 32'(fr[5]));
        for (int i = 7; i < pos; i++)
            chk(txlog[i] == 8'hFF, {"R10 fill byte ", tag}, 32'(txlog[i]), 32'hFF);
        chk(got_clr == (e_err == 0), {"R9 pos_clr ", tag}, 32'(got_clr), 32'(e_err == 0));
        if (e_err == 0) begin
            exp_bs = bs;
            exp_bc = bc;
        end
        @(negedge clk); #1;
        chk(!done, {"R10 done pulse ", tag}, 32'(done), 32'd0);
        chk(blk_size_o == exp_bs && blk_count_o == exp_bc, {"R9 block latch ", tag},
            {blk_size_o, blk_count_o}, {exp_bs, exp_bc});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!done && !xfer_req && err_code == 0 && resp == 0, "R1 reset state",
            {done, xfer_req, err_code, resp[7:0]}, 32'd0);
        chk(blk_size_o == 0 && blk_count_o == 0, "R9 reset block", {blk_size_o, blk_count_o}, 0);
        repeat (4) @(negedge clk);
        chk(!xfer_req, "R1 idle quiet", 32'(xfer_req), 0);

        // R2 R3: every command index
        for (int i = 0; i < 64; i++)
            run(6'(i), (32'(i) * 32'h0103_0507) ^ 32'hA5C3_0F1E, 0, 0, 0, 0, 8'h00, 0, 0,
                16'(i + 1), 16'(3 * i), "idx sweep");
        // R4 R5: every arrival slot, plus none
        for (int d = 0; d <= HT; d++)
            run(6'd17, 32'h1234_5678, 0, 0, 0, d, 8'h01, 0, 0, 16'h0200, 16'(d), "hunt slot");
        // R6: every R1 with bit 7 clear
        for (int r = 0; r < 128; r++)
            run(6'd24, 32'(r), 1, 1, 0, 2, 8'(r), 1, 32'h5A, 16'(r), 16'h7, "r1 sweep");
        // R7: busy length up to the limit
        for (int b = 0; b <= BL; b++)
            run(6'd12, 32'h0, 1, 0, 1, 1, 8'h00, b, 32'hC0DE_0000 + 32'(b),
                16'h40 + 16'(b), 16'h9, "busy len");
        // R8: trailing flags
        run(6'd8,  32'h1AA, 0, 1, 0, 0, 8'h01, 0, 32'hDEAD_BEEF, 16'h11, 16'h22, "byte only");
        run(6'd58, 32'h0,   0, 0, 1, 3, 8'h00, 0, 32'h89AB_CDEF, 16'h33, 16'h44, "word only");
        run(6'd58, 32'h0,   0, 1, 1, 0, 8'h00, 0, 32'h0102_0304, 16'h55, 16'h66, "both flags");
        // R9: error keeps previous geometry
        run(6'd1, 32'h0, 0, 0, 1, 0, 8'h08, 0, 32'h0, 16'hBEEF, 16'hCAFE, "crc err keeps");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule